// File: doc/BRIEF.md
# Serial Flash Controller Register Block

This block is the register front end of a serial NOR flash controller that serves up to three flash devices. A host reaches it through a small word-addressed register port. The block decodes reads and writes to seven 32-bit registers. It takes bulk-erase, sector-erase and protection commands through an operation register. It also watches write requests arriving from the controller's data path, which the block sees as a sector number with a valid strobe.

Each erase or write is checked against the block-protection window of the currently selected device. The window covers either the bottom or the top of the device, and its size is a power of two in sectors. A legal operation starts a cycle-count stub that stands in for the serial engine, and a busy flag reads high until the stub finishes. An operation that hits protected space is dropped and sets a sticky flag. These flags stay set until software writes a 1 to clear them. A mask register decides which flags drive the interrupt line.

Top module: `sflash_csr`

## Requirements
- R1: The register port uses word index `csr_addr`. Index 0 is status, 1 is silicon ID, 2 is read ID, 3 is operation, 4 is interrupt flags, 5 is interrupt mask and 6 is chip select. A read returns data on `csr_rdata` with `csr_rvalid` high one cycle later. The silicon ID and read ID return the `SILICON_ID` and `READ_ID` parameters. The operation register and index 7 read as 0, and status reads 0 after reset.
- R2: Chip select resets to 1, which selects device 0, and `dev_sel` shows its value. A write of exactly one set bit within bits [2:0], with all other bits zero, selects that device: 1, 2 or 4 select devices 0, 1 and 2. Any other value is ignored.
- R3: An operation write with bits [1:0]=3 stores bits [11:8] as the protection level and bit 12 as the bottom-select flag of the selected device. Status then shows level bits 0, 1, 2 and 3 at bits 2, 3, 4 and 6, and the bottom-select flag at bit 5. Writing level 0 removes all protection.
- R4: An accepted erase or write sets status bit 0 (in progress) and bit 1 (write enabled) from the next cycle. Both stay set for `BUSY_CYCLES` cycles. With a read captured k cycles after the accepting edge, both bits read 1 for k up to `BUSY_CYCLES` and 0 at `BUSY_CYCLES`+1.
- R5: While the in-progress bit is set, operation writes and write requests are ignored. They change no protection setting, start nothing and set no flag.
- R6: With bottom-select set and level k from 1 to 10, sectors below 2^(k-1) are protected. A level whose window would cover the whole device or more protects every sector.
- R7: With bottom-select clear, level log2(`SECTOR_COUNT`) protects the upper half of the device. Each level below that halves the protected top region, and a level above it protects every sector.
- R8: A bulk erase (bits [1:0]=1) is illegal whenever the level is nonzero. A sector erase (bits [1:0]=2, sector in bits [17:8]) is illegal when its sector number is `SECTOR_COUNT` or above.
- R9: An illegal erase sets interrupt flag bit 0 and an illegal write sets bit 1. Neither starts the busy period.
- R10: An interrupt flag stays set until a write to the flag register has a 1 in its bit. If a new event and a clear arrive in the same cycle, the event wins.
- R11: `irq` is high exactly when some flag is set and its mask bit (bit 0 for erase, bit 1 for write) is 1.
- R12: Each device keeps its own protection setting. Status and the checks always use the setting of the device that chip select currently points to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_valid | input | 1 | Register access request |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 3 | Register word index |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, registered |
| csr_rvalid | output | 1 | Read data valid, one cycle after the request |
| prog_valid | input | 1 | Data-path write request |
| prog_sector | input | 10 | Sector targeted by the write request |
| dev_sel | output | 3 | One-hot selected device |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong protection window shows up at once as an interrupt flag on a legal operation, or as a busy status after an operation that should have been refused. These are seen on `irq` in the cycle after the request, and in the next status read. A busy counter that is off by one cycle shifts where the in-progress bit falls, so status is read right at the last busy cycle and again one cycle later. Protection state held for the wrong device appears in the first status read after chip select changes. Stale flags show in the flag register read that follows each write-one-to-clear.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam int SECT_FIELD_W = 10;
  localparam int FLAG_COUNT   = 2;

  typedef enum logic [2:0] {
    CSR_STATUS = 3'd0,
    CSR_SID    = 3'd1,
    CSR_RDID   = 3'd2,
    CSR_MEMOP  = 3'd3,
    CSR_ISR    = 3'd4,
    CSR_IMR    = 3'd5,
    CSR_CSEL   = 3'd6
  } csr_word_e;

  typedef enum logic [1:0] {
    OP_IDLE         = 2'd0,
    OP_BULK_ERASE   = 2'd1,
    OP_SECTOR_ERASE = 2'd2,
    OP_SET_PROTECT  = 2'd3
  } memop_e;

  typedef struct packed {
    logic       from_bottom;
    logic [3:0] level;
  } prot_cfg_t;

  function automatic logic [31:0] pack_status(input logic wip, input logic wel,
                                              input prot_cfg_t cfg);
    logic [31:0] s;
    s    = '0;
    s[0] = wip;
    s[1] = wel;
    s[2] = cfg.level[0];
    s[3] = cfg.level[1];
    s[4] = cfg.level[2];
    s[5] = cfg.from_bottom;
    s[6] = cfg.level[3];
    return s;
  endfunction

endpackage

// File: rtl/sfc_prot_check.sv
module sfc_prot_check
  import sfc_pkg::*;
#(
  parameter int SECTOR_COUNT = 512
) (
  input  prot_cfg_t                cfg_i,
  input  logic [SECT_FIELD_W-1:0]  sector_i,
  output logic                     blocked_o
);

  localparam int LOG2_SECT = $clog2(SECTOR_COUNT);
  localparam int AW        = SECT_FIELD_W + 1;
  localparam logic [AW-1:0] TOTAL = AW'(SECTOR_COUNT);

  logic [AW-1:0] sec_ext;
  logic [AW-1:0] low_limit;
  logic [AW-1:0] high_base;
  logic          in_range;
  logic          hit_bottom;
  logic          hit_top;

  always_comb begin
    sec_ext    = {1'b0, sector_i};
    in_range   = (sec_ext < TOTAL);
    low_limit  = '0;
    high_base  = TOTAL;
    hit_bottom = 1'b0;
    hit_top    = 1'b0;
    if (cfg_i.level != 4'd0) begin
      if (cfg_i.from_bottom) begin
        if ((int'(cfg_i.level) - 1) >= LOG2_SECT) begin
          hit_bottom = 1'b1;
        end else begin
          low_limit  = AW'(1) << (cfg_i.level - 4'd1);
          hit_bottom = (sec_ext < low_limit);
        end
      end else begin
        if (int'(cfg_i.level) > LOG2_SECT) begin
          hit_top = 1'b1;
        end else begin
          high_base = TOTAL - (TOTAL >> (LOG2_SECT + 1 - int'(cfg_i.level)));
          hit_top   = (sec_ext >= high_base);
        end
      end
    end
    blocked_o = !in_range || hit_bottom || hit_top;
  end

endmodule

// File: rtl/sfc_busy_stub.sv
module sfc_busy_stub #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = start_i ? LOAD : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  // R5: the command logic never launches a new operation into a running one
  p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

  // R4: an accepted start makes the engine busy on the following cycle
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

endmodule

// File: rtl/sfc_irq_regs.sv
module sfc_irq_regs #(
  parameter int SRC_COUNT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] set_i,
  input  logic                 clr_we_i,
  input  logic                 mask_we_i,
  input  logic [SRC_COUNT-1:0] wdata_i,
  output logic [SRC_COUNT-1:0] flags_o,
  output logic [SRC_COUNT-1:0] mask_o,
  output logic                 irq_o
);

  logic [SRC_COUNT-1:0] flags_q, flags_d;
  logic [SRC_COUNT-1:0] mask_q;
  logic [SRC_COUNT-1:0] clr_bits;
  logic                 flags_en;

  always_comb begin
    clr_bits = clr_we_i ? wdata_i : '0;
    flags_en = clr_we_i || (|set_i);
    flags_d  = (flags_q & ~clr_bits) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= wdata_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);

  for (genvar g = 0; g < SRC_COUNT; g++) begin : g_flag_chk
    // R9: a reported violation is latched
    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_o[g]);
    // R10: a flag holds until a 1 is written to its bit
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[g] && !(clr_we_i && wdata_i[g])) |=> flags_o[g]);
  end

  // R11: the line only rises for an unmasked source
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|mask_o));

endmodule

// File: rtl/sflash_csr.sv
module sflash_csr
  import sfc_pkg::*;
#(
  parameter int          SECTOR_COUNT = 512,
  parameter int          BUSY_CYCLES  = 64,
  parameter int          DEV_COUNT    = 3,
  parameter logic [31:0] SILICON_ID   = 32'h0000_0016,
  parameter logic [31:0] READ_ID      = 32'h0000_0018
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csr_valid,
  input  logic                    csr_write,
  input  logic [2:0]              csr_addr,
  input  logic [31:0]             csr_wdata,
  output logic [31:0]             csr_rdata,
  output logic                    csr_rvalid,
  input  logic                    prog_valid,
  input  logic [SECT_FIELD_W-1:0] prog_sector,
  output logic [DEV_COUNT-1:0]    dev_sel,
  output logic                    irq
);

  localparam int CFG_W = $bits(prot_cfg_t);
  localparam logic [DEV_COUNT-1:0] CSEL_RESET = DEV_COUNT'(1);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // access decode
  csr_word_e word_sel;
  logic      wr_any;
  logic      memop_wr_raw;
  logic      isr_we;
  logic      imr_we;
  logic      csel_we;
  logic      rd_en;
  memop_e    op_code;
  logic      busy;

  always_comb begin
    word_sel     = csr_word_e'(csr_addr);
    wr_any       = csr_valid && csr_write;
    rd_en        = csr_valid && !csr_write;
    memop_wr_raw = wr_any && (word_sel == CSR_MEMOP);
    isr_we       = wr_any && (word_sel == CSR_ISR);
    imr_we       = wr_any && (word_sel == CSR_IMR);
    csel_we      = wr_any && (word_sel == CSR_CSEL)
                   && $onehot(csr_wdata[DEV_COUNT-1:0])
                   && (csr_wdata[31:DEV_COUNT] == '0);
    op_code      = memop_e'(csr_wdata[1:0]);
  end

  // chip select
  logic [DEV_COUNT-1:0] csel_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      csel_q <= CSEL_RESET;
    end else if (csel_we) begin
      csel_q <= csr_wdata[DEV_COUNT-1:0];
    end
  end
  assign dev_sel = csel_q;

  // per-device protection settings
  logic [DEV_COUNT-1:0][CFG_W-1:0] prot_q;
  logic [CFG_W-1:0]                prot_wr_val;
  logic [CFG_W-1:0]                cur_cfg_bits;
  prot_cfg_t                       cur_cfg;
  logic                            prot_we;

  always_comb begin
    prot_wr_val  = csr_wdata[8 +: CFG_W];
    cur_cfg_bits = '0;
    for (int d = 0; d < DEV_COUNT; d++) begin
      if (csel_q[d]) cur_cfg_bits = cur_cfg_bits | prot_q[d];
    end
    cur_cfg = prot_cfg_t'(cur_cfg_bits);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      prot_q <= '0;
    end else begin
      for (int d = 0; d < DEV_COUNT; d++) begin
        if (prot_we && csel_q[d]) prot_q[d] <= prot_wr_val;
      end
    end
  end

  // command sequencing and protection checks
  logic bulk_req, sect_req, prog_req;
  logic sect_blocked, prog_blocked;
  logic erase_bad, erase_ok, prog_bad, prog_ok, start;

  sfc_prot_check #(
    .SECTOR_COUNT (SECTOR_COUNT)
  ) u_chk_erase (
    .cfg_i     (cur_cfg),
    .sector_i  (csr_wdata[8 +: SECT_FIELD_W]),
    .blocked_o (sect_blocked)
  );

  sfc_prot_check #(
    .SECTOR_COUNT (SECTOR_COUNT)
  ) u_chk_prog (
    .cfg_i     (cur_cfg),
    .sector_i  (prog_sector),
    .blocked_o (prog_blocked)
  );

  always_comb begin
    bulk_req  = memop_wr_raw && !busy && (op_code == OP_BULK_ERASE);
    sect_req  = memop_wr_raw && !busy && (op_code == OP_SECTOR_ERASE);
    prot_we   = memop_wr_raw && !busy && (op_code == OP_SET_PROTECT);
    erase_bad = (bulk_req && (cur_cfg.level != 4'd0)) || (sect_req && sect_blocked);
    erase_ok  = (bulk_req || sect_req) && !erase_bad;
    prog_req  = prog_valid && !busy && !(bulk_req || sect_req);
    prog_bad  = prog_req && prog_blocked;
    prog_ok   = prog_req && !prog_blocked;
    start     = erase_ok || prog_ok;
  end

  sfc_busy_stub #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start),
    .busy_o  (busy)
  );

  logic [FLAG_COUNT-1:0] isr_bits, imr_bits;

  sfc_irq_regs #(
    .SRC_COUNT (FLAG_COUNT)
  ) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     ({prog_bad, erase_bad}),
    .clr_we_i  (isr_we),
    .mask_we_i (imr_we),
    .wdata_i   (csr_wdata[FLAG_COUNT-1:0]),
    .flags_o   (isr_bits),
    .mask_o    (imr_bits),
    .irq_o     (irq)
  );

  // read path
  logic [31:0] rd_d, rdata_q;
  logic        rvalid_q;

  always_comb begin
    unique case (word_sel)
      CSR_STATUS: rd_d = pack_status(busy, busy, cur_cfg);
      CSR_SID:    rd_d = SILICON_ID;
      CSR_RDID:   rd_d = READ_ID;
      CSR_ISR:    rd_d = 32'(isr_bits);
      CSR_IMR:    rd_d = 32'(imr_bits);
      CSR_CSEL:   rd_d = 32'(csel_q);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
    end
  end

  assign csr_rdata  = rdata_q;
  assign csr_rvalid = rvalid_q;

  // R2: exactly one device is selected at all times
  p_csel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(csel_q) == 1);

  // R9: a refused operation leaves the engine idle
  p_reject_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (erase_bad || prog_bad) |=> !busy);

  // R5: operation writes during busy leave the protection window untouched
  p_busy_keeps_cfg_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && memop_wr_raw && !csel_we) |=> $stable(cur_cfg));

  // R1: read data is presented one cycle after each read request
  p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> csr_rvalid);

endmodule

// File: tb/sflash_csr_bench.sv
module sflash_csr_bench;

  localparam int          BUSY = 6;
  localparam logic [31:0] SID  = 32'h0000_0014;
  localparam logic [31:0] RID  = 32'h0000_0019;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_valid, csr_write;
  logic [2:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;
  logic        prog_valid;
  logic [9:0]  prog_sector;
  logic [2:0]  dev_sel;
  logic        irq;

  always #4 clk = ~clk;

  sflash_csr #(
    .SECTOR_COUNT (512),
    .BUSY_CYCLES  (BUSY),
    .DEV_COUNT    (3),
    .SILICON_ID   (SID),
    .READ_ID      (RID)
  ) u_sflash_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_write   (csr_write),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata),
    .csr_rvalid  (csr_rvalid),
    .prog_valid  (prog_valid),
    .prog_sector (prog_sector),
    .dev_sel     (dev_sel),
    .irq         (irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && csr_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected read response", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
      end
    end
  end

  // status word built from the bit positions of R3 and R4
  function automatic logic [31:0] stat(input logic busy, input logic [3:0] lvl, input logic bottom);
    logic [31:0] s;
    s = '0;
    s[0] = busy; s[1] = busy;
    s[2] = lvl[0]; s[3] = lvl[1]; s[4] = lvl[2]; s[6] = lvl[3];
    s[5] = bottom;
    return s;
  endfunction

  function automatic logic [31:0] prot_cmd(input logic [3:0] lvl, input logic bottom);
    return (32'(bottom) << 12) | (32'(lvl) << 8) | 32'd3;
  endfunction

  function automatic logic [31:0] sect_cmd(input int sector);
    return ((32'(sector) & 32'h3FF) << 8) | 32'd2;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_valid = 1'b0; csr_write = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    csr_valid = 1'b1; csr_write = 1'b0; csr_addr = a;
    @(negedge clk);
    csr_valid = 1'b0;
  endtask

  task automatic prog(input int sector);
    prog_valid = 1'b1; prog_sector = 10'(sector);
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_valid = 1'b0; csr_write = 1'b0; csr_addr = '0;
    csr_wdata = '0; prog_valid = 1'b0; prog_sector = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 / R2 reset state and identification
    csr_rd(3'd0, 32'h0, "R1 status after reset");
    csr_rd(3'd1, SID, "R1 silicon id");
    csr_rd(3'd2, RID, "R1 read id");
    csr_rd(3'd3, 32'h0, "R1 operation reads zero");
    csr_rd(3'd7, 32'h0, "R1 unused index");
    csr_rd(3'd6, 32'h1, "R2 chip select reset");
    csr_rd(3'd4, 32'h0, "R10 flags after reset");
    check("R2 dev_sel after reset", 32'(dev_sel), 32'h1);
    check("R11 irq after reset", 32'(irq), 32'h0);

    csr_wr(3'd5, 32'h3);
    csr_rd(3'd5, 32'h3, "R11 mask readback");

    // R3 / R6 bottom window level 5 covers sectors 0..15
    csr_wr(3'd3, prot_cmd(4'd5, 1'b1));
    csr_rd(3'd0, stat(1'b0, 4'd5, 1'b1), "R3 status bottom level 5");
    prog(15);
    check("R9 irq on illegal write", 32'(irq), 32'h1);
    csr_rd(3'd4, 32'h2, "R6 write to sector 15 refused");
    csr_rd(3'd0, stat(1'b0, 4'd5, 1'b1), "R9 no busy after refused write");
    prog(16);
    csr_rd(3'd0, stat(1'b1, 4'd5, 1'b1), "R6 write to sector 16 accepted");
    idle(BUSY + 2);
    csr_wr(3'd3, sect_cmd(0));
    csr_rd(3'd4, 32'h3, "R9 illegal erase flag");

    // R10 write-one-to-clear
    csr_wr(3'd4, 32'h1);
    csr_rd(3'd4, 32'h2, "R10 clear erase flag only");
    csr_wr(3'd4, 32'h2);
    csr_rd(3'd4, 32'h0, "R10 clear write flag");
    check("R11 irq low after clear", 32'(irq), 32'h0);

    // R11 masking
    csr_wr(3'd5, 32'h0);
    prog(3);
    check("R11 masked flag keeps irq low", 32'(irq), 32'h0);
    csr_rd(3'd4, 32'h2, "R11 flag set while masked");
    csr_wr(3'd5, 32'h2);
    check("R11 unmask raises irq", 32'(irq), 32'h1);
    csr_wr(3'd4, 32'h3);
    check("R11 irq low after clear", 32'(irq), 32'h0);

    // R7 top windows
    csr_wr(3'd3, prot_cmd(4'd9, 1'b0));
    csr_rd(3'd0, stat(1'b0, 4'd9, 1'b0), "R3 status top level 9");
    csr_wr(3'd3, sect_cmd(255));
    csr_rd(3'd0, stat(1'b1, 4'd9, 1'b0), "R7 erase 255 allowed at level 9");
    idle(BUSY + 2);
    csr_wr(3'd3, sect_cmd(256));
    csr_rd(3'd4, 32'h1, "R7 erase 256 refused at level 9");
    csr_wr(3'd4, 32'h1);
    csr_wr(3'd3, prot_cmd(4'd8, 1'b0));
    prog(383);
    csr_rd(3'd0, stat(1'b1, 4'd8, 1'b0), "R7 write 383 allowed at level 8");
    idle(BUSY + 2);
    prog(384);
    csr_rd(3'd4, 32'h2, "R7 write 384 refused at level 8");
    csr_wr(3'd4, 32'h2);

    // R8 bulk erase under protection
    csr_wr(3'd3, 32'h1);
    csr_rd(3'd4, 32'h1, "R8 bulk erase refused when protected");
    csr_wr(3'd4, 32'h1);

    // R6 oversized bottom level protects all
    csr_wr(3'd3, prot_cmd(4'd12, 1'b1));
    csr_wr(3'd3, sect_cmd(511));
    csr_rd(3'd4, 32'h1, "R6 level 12 bottom covers last sector");
    csr_wr(3'd4, 32'h1);

    // R3 clear, R5 busy ignore
    csr_wr(3'd3, 32'h3);
    csr_rd(3'd0, 32'h0, "R3 zero clears protection");
    csr_wr(3'd3, 32'h1);
    csr_wr(3'd3, prot_cmd(4'd3, 1'b0));
    csr_wr(3'd3, sect_cmd(600));
    prog(5);
    idle(BUSY + 2);
    csr_rd(3'd0, 32'h0, "R5 protect ignored while busy");
    csr_rd(3'd4, 32'h0, "R5 no flags while busy");
    csr_wr(3'd3, sect_cmd(600));
    csr_rd(3'd4, 32'h1, "R8 sector out of range refused");
    csr_wr(3'd4, 32'h1);

    // R4 busy span
    csr_wr(3'd3, sect_cmd(10));
    idle(BUSY - 1);
    csr_rd(3'd0, stat(1'b1, 4'd0, 1'b0), "R4 busy on last cycle");
    csr_rd(3'd0, 32'h0, "R4 busy cleared after span");

    // R2 / R12 chip select and per-device protection
    csr_wr(3'd6, 32'h2);
    check("R2 select device 1", 32'(dev_sel), 32'h2);
    csr_wr(3'd3, prot_cmd(4'd15, 1'b1));
    csr_rd(3'd0, stat(1'b0, 4'd15, 1'b1), "R12 device 1 protection");
    csr_wr(3'd6, 32'h3);
    check("R2 non one-hot ignored", 32'(dev_sel), 32'h2);
    csr_rd(3'd6, 32'h2, "R2 chip select readback");
    csr_wr(3'd6, 32'h1);
    csr_rd(3'd0, 32'h0, "R12 device 0 unprotected");
    prog(0);
    csr_rd(3'd0, stat(1'b1, 4'd0, 1'b0), "R12 device 0 write accepted");
    idle(BUSY + 2);
    csr_wr(3'd6, 32'h4);
    check("R2 select device 2", 32'(dev_sel), 32'h4);
    csr_rd(3'd0, 32'h0, "R12 device 2 unprotected");
    csr_wr(3'd6, 32'h2);
    prog(100);
    csr_rd(3'd4, 32'h2, "R12 device 1 refuses write");

    idle(4);
    if (exp_q.size() != 0) check("R1 responses outstanding", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule